// File: doc/BRIEF.md
# Line-Region Sequenced Clamp and Blanking Pulse Generator

This block drives the horizontal clamp and blanking outputs of an image-sensor timing generator: an optical-black clamp, a dummy-pixel clamp, a pixel blanking pulse, and a horizontal blanking pulse. While the blanking pulse is active, the H1 clock is held at a programmed level, and that level is brought out as a separate output. External counters supply the pixel position within the line and the line position within the field. The block itself keeps no counters.

Each output has four pulse shapes, called sequences. A shape is a level at the start of the line plus two pixel positions where the level inverts. A field is split into up to four vertical regions by three programmable line numbers, called change points. A pointer for each region picks which of the four sequences every output uses on the lines of that region.

Parameters are loaded through a simple write port into a pending bank. The pending bank is copied into the working bank only on a field-start strobe. As a result, the outputs never change shape in the middle of a field.

Top module: `lrspg_top`

## Requirements
- R1: The active region is 0 unless lineCnt is at or above a change point. Otherwise it is the highest-numbered region n (1..3) whose change point is at or below lineCnt. Change points are assumed ascending.
- R2: The active region's 2-bit pointer selects the sequence (0..3) that all five outputs use on that line.
- R3: For clampOb, clampDummy and pixBlank, the level at pixCnt 0 is the sequence's start level. The level inverts at the pixel equal to toggle A and again at the pixel equal to toggle B. Each output is registered, so it shows the effect of a pixCnt/lineCnt value one clock later.
- R4: A toggle placed at pixel 0 inverts the start level on that same pixel. Two equal toggle positions cancel, and the output does not change at that pixel.
- R5: hBlank starts every line low and follows the same two-toggle rule with its own positions. h1Level carries the selected hBlank sequence's hold level (0 = H1 low, 1 = H1 high), also registered one clock later.
- R6: Write map: addresses 0..2 set change points 1..3 from data[11:0]. Address 3 sets the pointers, with region r in data[2r+1:2r]. Address 8+8k+2s+h selects output k (0 clampOb, 1 clampDummy, 2 pixBlank, 3 hBlank) and sequence s. When h=0 it sets toggle A from data[11:0] and the start/hold level from data[12]; when h=1 it sets toggle B from data[11:0]. Writes to all other addresses change nothing.
- R7: Writes land in the pending bank only. The outputs keep using the working bank until a clock edge where fieldStart is high copies the whole pending bank into it.
- R8: A write in the same cycle as fieldStart is kept in the pending bank and takes effect only at the following fieldStart.
- R9: While reset is asserted, all outputs are low. After reset, every parameter in both banks is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fieldStart | input | 1 | Field-start strobe; commits the pending bank |
| pixCnt | input | 12 | Pixel position within the line |
| lineCnt | input | 12 | Line position within the field |
| wrEn | input | 1 | Parameter write enable |
| wrAddr | input | 6 | Parameter write address |
| wrData | input | 13 | Parameter write data |
| clampOb | output | 1 | Optical-black clamp pulse |
| clampDummy | output | 1 | Dummy-pixel clamp pulse |
| pixBlank | output | 1 | Pixel blanking pulse |
| hBlank | output | 1 | Horizontal blanking pulse (H1 held while high) |
| h1Level | output | 1 | Level at which H1 is held during blanking |

## Verification
Two events can fall in the same cycle: a parameter write and the field-start commit. The bench provokes this by writing the pointer register on the very clock that fieldStart is high. It then judges the result over two fields. The first must still follow the old pointers, and the second must follow the new ones. A second coincidence, two toggles on the same pixel, is provoked with equal positions and with a toggle at pixel 0. It is judged against the start level that the requirements predict.

// File: rtl/lrspg_pkg.sv
package lrspg_pkg;
  parameter int PIX_W  = 12;
  parameter int LINE_W = 12;
  parameter int N_REG  = 4;
  parameter int N_SEQ  = 4;
  parameter int N_OUT  = 4;
  parameter int ADDR_W = 6;

  localparam int SEL_W    = $clog2(N_SEQ);
  localparam int REG_W    = $clog2(N_REG);
  localparam int OUT_W    = $clog2(N_OUT);
  localparam int DATA_W   = PIX_W + 1;
  localparam int SEQ_BASE = 2 * N_REG;
  localparam int SEQ_SPAN = N_OUT * N_SEQ * 2;

  // strobes from control to datapath
  typedef struct packed {
    logic             commit;
    logic             seqWe;
    logic [OUT_W-1:0] seqOut;
    logic [SEL_W-1:0] seqIdx;
    logic             seqHalf;
    logic [REG_W-1:0] region;
    logic [SEL_W-1:0] seqSel;
  } strobe_t;
endpackage

// File: rtl/lrspg_ctrl.sv
module lrspg_ctrl
  import lrspg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStart,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINE_W-1:0] lineCnt,
  output strobe_t           stb
);
  localparam int PTR_ADDR = N_REG - 1;

  // entry 0 is the fixed line-0 change point and stays zero
  logic [LINE_W-1:0] cpPend  [N_REG];
  logic [LINE_W-1:0] cpAct   [N_REG];
  logic [SEL_W-1:0]  ptrPend [N_REG];
  logic [SEL_W-1:0]  ptrAct  [N_REG];
  logic [ADDR_W-1:0] seqOff;
  logic              seqHit;
  logic [REG_W-1:0]  region;

  assign seqOff = wrAddr - ADDR_W'(SEQ_BASE);
  assign seqHit = wrEn && (wrAddr >= ADDR_W'(SEQ_BASE)) && (seqOff < ADDR_W'(SEQ_SPAN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < N_REG; r++) begin
        cpPend[r]  <= '0;
        cpAct[r]   <= '0;
        ptrPend[r] <= '0;
        ptrAct[r]  <= '0;
      end
    end else begin
      if (fieldStart) begin
        for (int r = 0; r < N_REG; r++) begin
          cpAct[r]  <= cpPend[r];
          ptrAct[r] <= ptrPend[r];
        end
      end
      if (wrEn) begin
        for (int r = 1; r < N_REG; r++)
          if (wrAddr == ADDR_W'(r - 1)) cpPend[r] <= wrData[LINE_W-1:0];
        if (wrAddr == ADDR_W'(PTR_ADDR))
          for (int r = 0; r < N_REG; r++) ptrPend[r] <= wrData[r*SEL_W +: SEL_W];
      end
    end
  end

  // highest region whose change point is reached
  always_comb begin
    region = '0;
    for (int r = 1; r < N_REG; r++)
      if (lineCnt >= cpAct[r]) region = REG_W'(r);
  end

  always_comb begin
    stb.commit  = fieldStart;
    stb.seqWe   = seqHit;
    stb.seqHalf = seqOff[0];
    stb.seqIdx  = seqOff[1 +: SEL_W];
    stb.seqOut  = seqOff[1+SEL_W +: OUT_W];
    stb.region  = region;
    stb.seqSel  = ptrAct[region];
  end
endmodule

// File: rtl/lrspg_dpath.sv
module lrspg_dpath
  import lrspg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PIX_W-1:0]  pixCnt,
  output logic [N_OUT-1:0]  pulse,
  output logic              h1Level
);
  logic lineHead;
  assign lineHead = (pixCnt == '0);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic             polPend [N_SEQ];
    logic             polAct  [N_SEQ];
    logic [PIX_W-1:0] togAPend [N_SEQ];
    logic [PIX_W-1:0] togAAct  [N_SEQ];
    logic [PIX_W-1:0] togBPend [N_SEQ];
    logic [PIX_W-1:0] togBAct  [N_SEQ];
    logic             startLvl, baseLvl, hitA, hitB, lvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int s = 0; s < N_SEQ; s++) begin
          polPend[s]  <= 1'b0;
          polAct[s]   <= 1'b0;
          togAPend[s] <= '0;
          togAAct[s]  <= '0;
          togBPend[s] <= '0;
          togBAct[s]  <= '0;
        end
      end else begin
        if (stb.commit) begin
          for (int s = 0; s < N_SEQ; s++) begin
            polAct[s]  <= polPend[s];
            togAAct[s] <= togAPend[s];
            togBAct[s] <= togBPend[s];
          end
        end
        if (stb.seqWe && stb.seqOut == OUT_W'(k)) begin
          if (stb.seqHalf) begin
            togBPend[stb.seqIdx] <= wrData[PIX_W-1:0];
          end else begin
            polPend[stb.seqIdx]  <= wrData[DATA_W-1];
            togAPend[stb.seqIdx] <= wrData[PIX_W-1:0];
          end
        end
      end
    end

    assign hitA = (pixCnt == togAAct[stb.seqSel]);
    assign hitB = (pixCnt == togBAct[stb.seqSel]);

    if (k == N_OUT - 1) begin : g_mask
      // blanking starts inactive; its level bit is the H1 hold level
      assign startLvl = 1'b0;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) h1Level <= 1'b0;
        else       h1Level <= polAct[stb.seqSel];
      end
    end else begin : g_clamp
      assign startLvl = polAct[stb.seqSel];
    end

    assign baseLvl = lineHead ? startLvl : lvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lvl <= 1'b0;
      else       lvl <= baseLvl ^ hitA ^ hitB;
    end

    assign pulse[k] = lvl;
  end
endmodule

// File: rtl/lrspg_top.sv
module lrspg_top
  import lrspg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fieldStart,
  input  logic [PIX_W-1:0]  pixCnt,
  input  logic [LINE_W-1:0] lineCnt,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              clampOb,
  output logic              clampDummy,
  output logic              pixBlank,
  output logic              hBlank,
  output logic              h1Level
);
  strobe_t          stb;
  logic [N_OUT-1:0] pulse;

  lrspg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .lineCnt(lineCnt), .stb(stb)
  );

  lrspg_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .pixCnt(pixCnt), .pulse(pulse), .h1Level(h1Level)
  );

  assign clampOb    = pulse[0];
  assign clampDummy = pulse[1];
  assign pixBlank   = pulse[2];
  assign hBlank     = pulse[3];
endmodule

// File: rtl/lrspg_chk.sv
module lrspg_chk
  import lrspg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [LINE_W-1:0] lineCnt,
  input strobe_t           stb,
  input logic              clampOb,
  input logic              clampDummy,
  input logic              pixBlank,
  input logic              hBlank,
  input logic              h1Level
);
  // R1: with ascending change points and no commit, rising lines never lower the region
  a_r1_region_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (($past(lineCnt) <= lineCnt) && !$past(stb.commit)) |-> (stb.region >= $past(stb.region)));

  // R2 / R7: the selected sequence moves only with the line or at a commit
  a_r2_sel_tracks_line: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(lineCnt) && !$past(stb.commit)) |-> $stable(stb.seqSel));

  // R5: the H1 hold level cannot change while the selection and the working bank stay put
  a_r5_h1_level_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stb.commit) && $stable(stb.seqSel)) |=> $stable(h1Level));

  // R9: every output is low while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r9_reset_low: assert ({clampOb, clampDummy, pixBlank, hBlank, h1Level} == 5'b0);
    end
  end
endmodule

bind lrspg_top lrspg_chk u_chk (
  .clk(clk), .rstN(rstN), .lineCnt(lineCnt), .stb(stb),
  .clampOb(clampOb), .clampDummy(clampDummy), .pixBlank(pixBlank),
  .hBlank(hBlank), .h1Level(h1Level)
);

// File: tb/sim_lrspg_top.sv
module sim_lrspg_top;
  import lrspg_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN, fieldStart, wrEn;
  logic [PIX_W-1:0]  pixCnt;
  logic [LINE_W-1:0] lineCnt;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic clampOb, clampDummy, pixBlank, hBlank, h1Level;

  lrspg_top u0 (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .pixCnt(pixCnt), .lineCnt(lineCnt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .clampOb(clampOb),
    .clampDummy(clampDummy), .pixBlank(pixBlank), .hBlank(hBlank), .h1Level(h1Level)
  );

  typedef struct { logic [4:0] exp; string req; } item_t;
  item_t q[$];
  int nChk = 0, nBad = 0;

  // reference model: pending and working banks
  int scpP[4], scpA[4], ptrP[4], ptrA[4];
  int t1P[4][4], t1A[4][4], t2P[4][4], t2A[4][4];
  bit polP[4][4], polA[4][4];
  bit lvl[4];

  task automatic check(input logic [4:0] got, input logic [4:0] exp, input string req);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b (h1Level,hBlank,pixBlank,clampDummy,clampOb)", req, got, exp);
    end
  endtask

  // monitor: compares each registered result one edge after its stimulus
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check({h1Level, hBlank, pixBlank, clampDummy, clampOb}, it.exp, it.req);
      end
    end
  end

  // driver: applies one cycle of stimulus and pushes the expected outputs
  task automatic drive(input int pix, input int line, input bit fs, input bit we,
                       input int addr, input int data, input string req);
    int r, s, off, k2, s2;
    bit base;
    logic [4:0] e;
    @(negedge clk);
    pixCnt = PIX_W'(pix); lineCnt = LINE_W'(line); fieldStart = fs;
    wrEn = we; wrAddr = ADDR_W'(addr); wrData = DATA_W'(data);
    r = 0;
    for (int n = 1; n < 4; n++) if (line >= scpA[n]) r = n;
    s = ptrA[r];
    for (int k = 0; k < 4; k++) begin
      base = (pix == 0) ? ((k == 3) ? 1'b0 : polA[k][s]) : lvl[k];
      lvl[k] = base ^ (pix == t1A[k][s]) ^ (pix == t2A[k][s]);
    end
    e = {polA[3][s], lvl[3], lvl[2], lvl[1], lvl[0]};
    q.push_back('{e, req});
    if (fs) begin
      scpA = scpP; ptrA = ptrP; t1A = t1P; t2A = t2P; polA = polP;
    end
    if (we) begin
      if (addr < 3) scpP[addr+1] = data & 4095;
      else if (addr == 3) for (int n = 0; n < 4; n++) ptrP[n] = (data >> (2*n)) & 3;
      else if (addr >= 8 && addr < 40) begin
        off = addr - 8; k2 = off >> 3; s2 = (off >> 1) & 3;
        if (off & 1) t2P[k2][s2] = data & 4095;
        else begin
          t1P[k2][s2] = data & 4095;
          polP[k2][s2] = (data >> 12) & 1;
        end
      end
    end
  endtask

  task automatic wr(input int addr, input int data, input string req);
    drive(0, 0, 1'b0, 1'b1, addr, data, req);
  endtask

  task automatic fieldGo(input string req);
    drive(0, 0, 1'b1, 1'b0, 0, 0, req);
  endtask

  task automatic runField(input bit midWr, input int wrLine, input int addr,
                          input int data, input string req);
    for (int l = 0; l < 8; l++)
      for (int p = 0; p < 16; p++)
        drive(p, l, 1'b0, midWr && l == wrLine && p == 3, addr, data, req);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
  end

  initial begin
    rstN = 1'b0; fieldStart = 1'b0; wrEn = 1'b0;
    pixCnt = '0; lineCnt = '0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    check({h1Level, hBlank, pixBlank, clampDummy, clampOb}, 5'b0, "R9 outputs in reset");
    @(negedge clk); rstN = 1'b1;

    runField(1'b0, 0, 0, 0, "R9 zero parameters after reset");

    // program: change points 2,4,6; pointers r0->1 r1->2 r2->0 r3->3
    wr(0, 2, "R6"); wr(1, 4, "R6"); wr(2, 6, "R6");
    wr(3, 1 | (2 << 2) | (0 << 4) | (3 << 6), "R6");
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++) begin
        int ta, tb, pol;
        pol = (k + s) & 1; ta = 2 + k + s; tb = 9 + s;
        if (k == 0 && s == 3) begin ta = 7; tb = 7; end  // R4 equal toggles
        if (k == 1 && s == 2) ta = 0;                     // R4 toggle at pixel 0
        wr(8 + 8*k + 2*s, (pol << 12) | ta, "R6");
        wr(9 + 8*k + 2*s, tb, "R6");
      end

    runField(1'b0, 0, 0, 0, "R7 pending bank not yet committed");
    fieldGo("R7 commit");
    runField(1'b0, 0, 0, 0, "R1 R2 R3 R4 R5 programmed field");

    runField(1'b1, 3, 3, 255, "R7 mid-field pointer write held");
    fieldGo("R7 commit");
    runField(1'b0, 0, 0, 0, "R2 all regions on sequence 3");

    drive(0, 0, 1'b1, 1'b1, 3, 1 | (2 << 2) | (3 << 6), "R8 write with fieldStart");
    runField(1'b0, 0, 0, 0, "R8 same-cycle write still pending");
    fieldGo("R8 commit");
    runField(1'b0, 0, 0, 0, "R8 same-cycle write applied");

    wr(5, 8191, "R6 unmapped"); wr(50, 8191, "R6 unmapped"); wr(0, 1, "R1");
    fieldGo("R6 commit");
    runField(1'b0, 0, 0, 0, "R6 R1 unmapped ignored, change point 1 at line 1");

    repeat (3) @(negedge clk);
    summary();
  end
endmodule